// File: doc/BRIEF.md
# Interrupt Vector Dispatch Unit

This block turns a request from one of four hardware sources (exception, timer, disk, console) or a software trap with a number into a new instruction pointer value. The vectors sit in a fixed, read-only window of memory just below the start of page 1, at addresses 492 to 511. The first four slots belong to the hardware sources. Trap numbers index the remaining slots directly, so trap n finds its vector at 492 + n.

When a request is accepted, the unit works out the slot address and reads that word from memory over a request/acknowledge handshake. It then sends the word it read back to the core as the new IP, together with a strobe that lasts one cycle. The core loads the handler address found in the slot, not the address of the slot.

The controller has three states. ST_IDLE waits for a request. ST_FETCH holds the read request until the memory acknowledges it. ST_LOAD drives the IP load strobe. There are four transitions:
- IDLE_TO_FETCH, taken when any source requests while idle.
- FETCH_WAIT, which stays in ST_FETCH while no acknowledge has arrived.
- FETCH_TO_LOAD, taken on the acknowledge.
- LOAD_TO_IDLE, taken unconditionally.

Top module: `vec_dispatch`

## Requirements
- R1: After reset, `ip_load`, `vec_rd_req` and `busy` are all low.
- R2: A single hardware request reads slot address 492 for the exception, 493 for the timer, 494 for the disk and 495 for the console.
- R3: A trap alone, with trap number n from 4 to 19, reads address 492 + n.
- R4: A trap alone, with a trap number below 4 or above 19, reads the exception slot at 492 instead.
- R5: When several sources request in the same cycle, the order of priority is exception, then timer, then disk, then console, then trap.
- R6: `ip_value` equals the data word returned by the memory read, not the slot address.
- R7: `vec_rd_req` stays high and `vec_rd_addr` stays unchanged until `vec_rd_ack` is seen, for any number of wait cycles.
- R8: `ip_load` rises in the cycle after the clock edge at which the acknowledge is taken, and it stays high for exactly one cycle.
- R9: Requests are sampled only in ST_IDLE. A request raised while `busy` is high is dropped and causes no further dispatch.
- R10: Every read address lies within the window 492 to 511. The unit has no write path, so it never changes the vector region.
- R11: With no request pending, the unit stays idle and issues no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_exc | input | 1 | Exception request (highest priority) |
| irq_timer | input | 1 | Timer interrupt request |
| irq_disk | input | 1 | Disk interrupt request |
| irq_console | input | 1 | Console interrupt request |
| trap_req | input | 1 | Software trap request (lowest priority) |
| trap_num | input | TRAP_W | Trap number n |
| vec_rd_req | output | 1 | Vector read request |
| vec_rd_addr | output | ADDR_W | Vector slot address |
| vec_rd_ack | input | 1 | Read acknowledge; data is valid |
| vec_rd_data | input | DATA_W | Word read from the vector slot |
| ip_load | output | 1 | One-cycle strobe to load IP |
| ip_value | output | DATA_W | Handler address to load into IP |
| busy | output | 1 | High outside ST_IDLE |

## Verification
The bench uses the default parameters: a 16-bit address and data path, a 5-bit trap number, a vector base of 492 and 20 slots. With a 5-bit trap number, every value from 0 to 31 can be driven, so both edges of the valid trap range and all the out-of-range values above 19 are reachable. The bench sweeps all 32 combinations of the four hardware lines and the trap line, and applies memory latencies of zero to three wait cycles. This covers every priority outcome and the ST_FETCH wait loop.

// File: rtl/vec_dispatch_pkg.sv
package vec_dispatch_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_LOAD  = 2'd2
    } disp_state_t;

    localparam int HW_SOURCES = 4;
endpackage

// File: rtl/vd_prio_arb.sv
module vd_prio_arb #(
    parameter int N     = 4,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    logic [N-1:0] blocked;
    logic [N-1:0] grant;

    // Lower index wins; each line is masked by every line ranked above it.
    for (genvar g = 0; g < N; g++) begin : g_chain
        if (g == 0) begin : g_first
            assign blocked[g] = 1'b0;
        end else begin : g_rest
            assign blocked[g] = blocked[g-1] | req[g-1];
        end
        assign grant[g] = req[g] & ~blocked[g];
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) idx = IDX_W'(i);
        end
    end

    assign hit = |req;
endmodule

// File: rtl/vd_slot_calc.sv
module vd_slot_calc #(
    parameter int HW_N      = 4,
    parameter int NUM_SLOTS = 20,
    parameter int TRAP_W    = 5,
    parameter int HW_IDX_W  = (HW_N > 1) ? $clog2(HW_N) : 1,
    parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic                hw_hit,
    input  logic [HW_IDX_W-1:0] hw_idx,
    input  logic                trap_req,
    input  logic [TRAP_W-1:0]   trap_num,
    output logic                start,
    output logic [SLOT_W-1:0]   slot
);
    localparam logic [TRAP_W-1:0] TRAP_LO = TRAP_W'(HW_N);
    localparam logic [TRAP_W-1:0] TRAP_HI = TRAP_W'(NUM_SLOTS - 1);
    localparam logic [SLOT_W-1:0] EXC_SLOT = '0;

    logic trap_ok;

    assign trap_ok = (trap_num >= TRAP_LO) && (trap_num <= TRAP_HI);
    assign start   = hw_hit | trap_req;

    always_comb begin
        if (hw_hit) begin
            slot = SLOT_W'(hw_idx);
        end else if (trap_ok) begin
            slot = trap_num[SLOT_W-1:0];
        end else begin
            slot = EXC_SLOT;
        end
    end
endmodule

// File: rtl/vd_fsm.sv
module vd_fsm
    import vec_dispatch_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              rd_ack,
    input  logic [DATA_W-1:0] rd_data,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              ip_load,
    output logic [DATA_W-1:0] ip_value,
    output logic              busy
);
    disp_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start)  state_nx = ST_FETCH;  // IDLE_TO_FETCH
            ST_FETCH: if (rd_ack) state_nx = ST_LOAD;   // FETCH_TO_LOAD, else FETCH_WAIT
            ST_LOAD:  state_nx = ST_IDLE;               // LOAD_TO_IDLE
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_addr  <= '0;
            ip_value <= '0;
        end else begin
            if (state == ST_IDLE && start) rd_addr <= start_addr;
            if (state == ST_FETCH && rd_ack) ip_value <= rd_data;
        end
    end

    always_comb begin
        rd_req  = 1'b0;
        ip_load = 1'b0;
        busy    = 1'b1;
        unique case (state)
            ST_IDLE:  busy    = 1'b0;
            ST_FETCH: rd_req  = 1'b1;
            ST_LOAD:  ip_load = 1'b1;
            default:  busy    = 1'b0;
        endcase
    end
endmodule

// File: rtl/vec_dispatch.sv
module vec_dispatch
    import vec_dispatch_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 16,
    parameter int TRAP_W    = 5,
    parameter int VEC_BASE  = 492,
    parameter int NUM_SLOTS = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_exc,
    input  logic              irq_timer,
    input  logic              irq_disk,
    input  logic              irq_console,
    input  logic              trap_req,
    input  logic [TRAP_W-1:0] trap_num,
    output logic              vec_rd_req,
    output logic [ADDR_W-1:0] vec_rd_addr,
    input  logic              vec_rd_ack,
    input  logic [DATA_W-1:0] vec_rd_data,
    output logic              ip_load,
    output logic [DATA_W-1:0] ip_value,
    output logic              busy
);
    localparam int HW_N     = HW_SOURCES;
    localparam int HW_IDX_W = $clog2(HW_N);
    localparam int SLOT_W   = $clog2(NUM_SLOTS);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(VEC_BASE);

    logic [HW_N-1:0]     hw_req;
    logic                hw_hit;
    logic [HW_IDX_W-1:0] hw_idx;
    logic                start;
    logic [SLOT_W-1:0]   slot;
    logic [ADDR_W-1:0]   slot_addr;

    // Bit order sets the ranking: exception first, console last.
    assign hw_req    = {irq_console, irq_disk, irq_timer, irq_exc};
    assign slot_addr = BASE_A + ADDR_W'(slot);

    vd_prio_arb #(.N(HW_N), .IDX_W(HW_IDX_W)) u_arb (
        .req (hw_req),
        .hit (hw_hit),
        .idx (hw_idx)
    );

    vd_slot_calc #(
        .HW_N(HW_N), .NUM_SLOTS(NUM_SLOTS), .TRAP_W(TRAP_W),
        .HW_IDX_W(HW_IDX_W), .SLOT_W(SLOT_W)
    ) u_slot (
        .hw_hit   (hw_hit),
        .hw_idx   (hw_idx),
        .trap_req (trap_req),
        .trap_num (trap_num),
        .start    (start),
        .slot     (slot)
    );

    vd_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_addr (slot_addr),
        .rd_ack     (vec_rd_ack),
        .rd_data    (vec_rd_data),
        .rd_req     (vec_rd_req),
        .rd_addr    (vec_rd_addr),
        .ip_load    (ip_load),
        .ip_value   (ip_value),
        .busy       (busy)
    );
endmodule

// File: rtl/vd_checker.sv
module vd_checker #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 16,
    parameter int TRAP_W    = 5,
    parameter int VEC_BASE  = 492,
    parameter int NUM_SLOTS = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_exc,
    input logic              irq_timer,
    input logic              irq_disk,
    input logic              irq_console,
    input logic              trap_req,
    input logic [TRAP_W-1:0] trap_num,
    input logic              vec_rd_req,
    input logic [ADDR_W-1:0] vec_rd_addr,
    input logic              vec_rd_ack,
    input logic [DATA_W-1:0] vec_rd_data,
    input logic              ip_load,
    input logic [DATA_W-1:0] ip_value,
    input logic              busy
);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(VEC_BASE);
    localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(VEC_BASE + NUM_SLOTS - 1);

    logic any_req;
    assign any_req = irq_exc | irq_timer | irq_disk | irq_console | trap_req;

    assert_rd_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
        vec_rd_req |-> (vec_rd_addr >= BASE_A && vec_rd_addr <= LAST_A));

    assert_rd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd_req && !vec_rd_ack) |=> (vec_rd_req && $stable(vec_rd_addr)));

    assert_load_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ip_load |=> !ip_load);

    assert_load_after_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ip_load |-> $past(vec_rd_req && vec_rd_ack));

    assert_value_is_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ip_load |-> (ip_value == $past(vec_rd_data)));

    assert_exc_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && irq_exc) |=> (vec_rd_req && vec_rd_addr == BASE_A));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !any_req) |=> (!busy && !vec_rd_req));

    assert_back_to_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ip_load |=> !busy);
endmodule

bind vec_dispatch vd_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TRAP_W(TRAP_W),
    .VEC_BASE(VEC_BASE), .NUM_SLOTS(NUM_SLOTS)
) u_vd_checker (
    .clk(clk), .rst_n(rst_n),
    .irq_exc(irq_exc), .irq_timer(irq_timer), .irq_disk(irq_disk),
    .irq_console(irq_console), .trap_req(trap_req), .trap_num(trap_num),
    .vec_rd_req(vec_rd_req), .vec_rd_addr(vec_rd_addr),
    .vec_rd_ack(vec_rd_ack), .vec_rd_data(vec_rd_data),
    .ip_load(ip_load), .ip_value(ip_value), .busy(busy)
);

// File: tb/tb_vec_dispatch.sv
`timescale 1ns/1ps
module tb_vec_dispatch;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 16;
    localparam int TRAP_W = 5;
    localparam int BASE   = 492;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              irq_exc = 0, irq_timer = 0, irq_disk = 0, irq_console = 0;
    logic              trap_req = 0;
    logic [TRAP_W-1:0] trap_num = '0;
    logic              vec_rd_req;
    logic [ADDR_W-1:0] vec_rd_addr;
    logic              vec_rd_ack = 1'b0;
    logic [DATA_W-1:0] vec_rd_data = '0;
    logic              ip_load;
    logic [DATA_W-1:0] ip_value;
    logic              busy;

    int checks = 0;
    int fails  = 0;
    int resp_lat = 0;
    int wcnt = 0;
    logic [ADDR_W-1:0] last_addr = '0;
    logic [ADDR_W-1:0] hold_addr = '0;

    always #2 clk = ~clk;

    vec_dispatch dut (
        .clk(clk), .rst_n(rst_n),
        .irq_exc(irq_exc), .irq_timer(irq_timer), .irq_disk(irq_disk),
        .irq_console(irq_console), .trap_req(trap_req), .trap_num(trap_num),
        .vec_rd_req(vec_rd_req), .vec_rd_addr(vec_rd_addr),
        .vec_rd_ack(vec_rd_ack), .vec_rd_data(vec_rd_data),
        .ip_load(ip_load), .ip_value(ip_value), .busy(busy)
    );

    function automatic logic [DATA_W-1:0] mem_word(input logic [ADDR_W-1:0] a);
        return DATA_W'(a * 37 + 16'h2000);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Memory model: acknowledges after resp_lat wait cycles.
    always @(negedge clk) begin
        if (vec_rd_ack) begin
            vec_rd_ack = 1'b0;
        end else if (vec_rd_req) begin
            if (wcnt > 0)
                check(vec_rd_addr == hold_addr, "R7 addr held", vec_rd_addr, hold_addr);
            hold_addr = vec_rd_addr;
            if (wcnt >= resp_lat) begin
                vec_rd_ack  = 1'b1;
                vec_rd_data = mem_word(vec_rd_addr);
                last_addr   = vec_rd_addr;
                wcnt = 0;
            end else begin
                wcnt++;
            end
        end
    end

    function automatic int exp_slot(input logic [3:0] hw, input bit tr, input int n);
        for (int i = 0; i < 4; i++) if (hw[i]) return i;
        if (tr && n >= 4 && n <= 19) return n;
        return 0;
    endfunction

    task automatic run_case(input logic [3:0] hw, input bit tr, input int n,
                            input int lat, input string tag);
        int ex_addr;
        bit found;
        ex_addr = BASE + exp_slot(hw, tr, n);
        @(negedge clk);
        resp_lat = lat;
        {irq_console, irq_disk, irq_timer, irq_exc} = hw;
        trap_req = tr;
        trap_num = TRAP_W'(n);
        @(negedge clk);
        {irq_console, irq_disk, irq_timer, irq_exc} = 4'b0;
        trap_req = 1'b0;
        found = 1'b0;
        for (int i = 0; i < 12 && !found; i++) begin
            if (ip_load) found = 1'b1;
            else @(negedge clk);
        end
        check(found, {tag, " R8 strobe seen"}, found, 1);
        check(last_addr == ADDR_W'(ex_addr), {tag, " slot address"}, last_addr, ex_addr);
        check(ip_value == mem_word(ADDR_W'(ex_addr)), {tag, " R6 ip_value"},
              ip_value, mem_word(ADDR_W'(ex_addr)));
        @(negedge clk);
        check(!ip_load && !busy, {tag, " R8 single pulse"}, {ip_load, busy}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!ip_load && !vec_rd_req && !busy, "R1 reset state",
              {ip_load, vec_rd_req, busy}, 0);

        // R11: no request, no read.
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check(!vec_rd_req && !busy, "R11 idle", {vec_rd_req, busy}, 0);
        end

        // R2: each hardware source alone.
        for (int s = 0; s < 4; s++)
            run_case(4'(1 << s), 1'b0, 0, s, "R2 single hw");

        // R3 / R4: every trap number alone, all latencies.
        for (int n = 0; n < 32; n++)
            run_case(4'b0, 1'b1, n, n % 4, (n >= 4 && n <= 19) ? "R3 trap" : "R4 trap range");

        // R5: every mix of hardware lines together with a trap.
        for (int m = 1; m < 32; m++)
            run_case(m[3:0], m[4], (m * 5) % 32, m % 4, "R5 priority");

        // R9: a request raised while busy is dropped.
        @(negedge clk);
        resp_lat = 3;
        irq_timer = 1'b1;
        @(negedge clk);
        irq_timer = 1'b0;
        irq_disk  = 1'b1;
        @(negedge clk);
        irq_disk  = 1'b0;
        for (int i = 0; i < 10 && !ip_load; i++) @(negedge clk);
        check(ip_value == mem_word(ADDR_W'(BASE + 1)), "R9 timer served", ip_value,
              mem_word(ADDR_W'(BASE + 1)));
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check(!vec_rd_req && !ip_load, "R9 no second dispatch", {vec_rd_req, ip_load}, 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule